// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

This block holds a bank of single-bit storage cells. A binary address picks one of them, and a serial data bit can be written into the selected cell. Two active-low controls, an enable and a clear, are combined to choose one of four modes:

- **Latch:** writes the data bit into the selected cell and leaves every other cell as it was.
- **Hold:** keeps every cell as it is.
- **Demux:** the selected output follows the data bit and every other output is forced low.
- **Clear:** forces every output low.

When the data bit is held high in demux mode, the block works as a binary-to-one-hot decoder.

Every mode takes effect on the rising clock edge, and the outputs come straight from registers. A synchronous active-high reset clears all cells. The parameter `N` sets the address width, and the output bus is `2**N` bits wide. To avoid writing to a cell that the address only passes through, the address should be changed while the block is in hold mode.

Top module: `addr_latch_demux`

## Requirements
- R1: When `rst` is high at a rising edge, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: In latch mode (`en_n`=0, `clr_n`=1), `q[sel]` takes the value of `din` at the rising edge.
- R3: In latch mode, every bit of `q` other than `q[sel]` keeps its previous value.
- R4: In hold mode (`en_n`=1, `clr_n`=1), `q` does not change, whatever `din` and `sel` do, including changes in several address bits at once.
- R5: In demux mode (`en_n`=0, `clr_n`=0), after the edge `q[sel]` equals `din` and every other bit is 0.
- R6: In clear mode (`en_n`=1, `clr_n`=0), every bit of `q` is 0 after the edge, whatever `din` and `sel` are.
- R7: In demux mode with `din`=1, `q` equals the one-hot value `1 << sel` for every address value.
- R8: After demux or clear mode, a return to hold mode keeps exactly the last registered value of `q`, including the forced zeros.
- R9: `sel` is an unsigned binary index, so `sel` = i addresses `q[i]`; `q` is `2**N` bits wide (default N=3, 8 outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| sel | input | N | Binary address of the target cell |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 2**N | Registered cell outputs |

## Verification
The hardest condition to reach from the ports is an address change while in hold mode that flips every address bit at once, with a non-trivial pattern already stored. The stimulus reaches it in three steps:

1. Latch writes at mixed addresses build an irregular pattern.
2. The block is switched to hold mode.
3. The address steps through pairs such as 0 to 7 and 5 to 2 while `din` toggles, and `q` is compared against the stored pattern after every edge.

A separate sequence covers the forced-zero case: it enters demux or clear mode over a full pattern, then returns to hold mode to confirm that the forced zeros persist.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_LATCH = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  en_n,
  input  logic  clr_n,
  output mode_e mode
);
  always_comb begin
    unique case ({en_n, clr_n})
      2'b01:   mode = MODE_LATCH;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
  parameter int N = 3
) (
  input  logic [N-1:0]      sel,
  output logic [(1<<N)-1:0] hit
);
  localparam int W = 1 << N;

  for (genvar i = 0; i < W; i++) begin : g_hit
    localparam logic [N-1:0] IDX = i;
    assign hit[i] = (sel == IDX);
  end
endmodule

// File: rtl/al_bit_cell.sv
module al_bit_cell
  import addr_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  hit,
  input  logic  din,
  output logic  q
);
  logic q_nxt;

  always_comb begin
    unique case (mode)
      MODE_LATCH: q_nxt = hit ? din : q;
      MODE_HOLD:  q_nxt = q;
      MODE_DEMUX: q_nxt = hit & din;
      default:    q_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import addr_latch_pkg::*;
#(
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [N-1:0]      sel,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [(1<<N)-1:0] q
);
  localparam int W = 1 << N;

  mode_e        mode;
  logic [W-1:0] hit;

  al_mode_dec u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  al_addr_dec #(.N(N)) u_addr (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    al_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
  parameter int N = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              din,
  input logic [N-1:0]      sel,
  input logic              en_n,
  input logic              clr_n,
  input logic [(1<<N)-1:0] q
);
  localparam int W = 1 << N;
  localparam logic [W-1:0] ONE = W'(1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> (q[$past(sel)] == $past(din))); // R2

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> ((q & ~(ONE << $past(sel))) == ($past(q) & ~(ONE << $past(sel))))); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q)); // R4

  AST_DEMUX_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> (q == ($past(din) ? (ONE << $past(sel)) : '0))); // R5

  AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> $onehot0(q)); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q == '0)); // R6
endmodule

bind addr_latch_demux addr_latch_demux_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .din   (din),
  .sel   (sel),
  .en_n  (en_n),
  .clr_n (clr_n),
  .q     (q)
);

// File: tb/addr_latch_demux_tb.sv
module addr_latch_demux_tb;
  localparam int N = 3;
  localparam int W = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         din = 1'b0;
  logic [N-1:0] sel = '0;
  logic         en_n = 1'b1;
  logic         clr_n = 1'b1;
  logic [W-1:0] q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  always #4 clk = ~clk;

  addr_latch_demux #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  // Driver: drives on the falling edge, updates the model, queues the expectation
  task automatic drive(input logic r, input logic d, input logic [N-1:0] s,
                       input logic e, input logic c, input string tag);
    @(negedge clk);
    rst = r; din = d; sel = s; en_n = e; clr_n = c;
    if (r) model = '0;
    else begin
      case ({e, c})
        2'b01: model[s] = d;
        2'b11: model = model;
        2'b00: begin model = '0; model[s] = d; end
        default: model = '0;
      endcase
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (q !== e) begin
        errors++;
        $display("FAIL %s: q=%b expected=%b", t, q, e);
      end
    end
  end

  initial begin
    // R1 reset state
    drive(1, 1, 3'd5, 0, 1, "R1");
    drive(1, 0, 3'd0, 0, 0, "R1");
    // R2/R3/R9 latch each address in turn, with alternating data
    for (int i = 0; i < W; i++) drive(0, i[0], N'(i), 0, 1, "R2");
    for (int i = W - 1; i >= 0; i--) drive(0, (i % 3) == 0, N'(i), 0, 1, "R3");
    drive(0, 1, 3'd6, 0, 1, "R9");
    // R4 hold with multi-bit address changes and toggling data
    drive(0, 1, 3'd0, 1, 1, "R4");
    drive(0, 0, 3'd7, 1, 1, "R4");
    drive(0, 1, 3'd5, 1, 1, "R4");
    drive(0, 0, 3'd2, 1, 1, "R4");
    drive(0, 1, 3'd1, 1, 1, "R4");
    drive(0, 0, 3'd6, 1, 1, "R4");
    // R7 decoder over every address
    for (int i = 0; i < W; i++) drive(0, 1, N'(i), 0, 0, "R7");
    // R8 hold after demux keeps the one-hot value
    drive(0, 0, 3'd0, 1, 1, "R8");
    drive(0, 1, 3'd3, 1, 1, "R8");
    // R5 demux with din=0, and din=1 after a latched pattern
    for (int i = 0; i < W; i++) drive(0, 1, N'(i), 0, 1, "R2");
    drive(0, 0, 3'd4, 0, 0, "R5");
    for (int i = 0; i < W; i++) drive(0, 1, N'(i), 0, 1, "R2");
    drive(0, 1, 3'd2, 0, 0, "R5");
    // R6 clear over a full pattern
    for (int i = 0; i < W; i++) drive(0, 1, N'(i), 0, 1, "R2");
    drive(0, 1, 3'd7, 1, 0, "R6");
    drive(0, 1, 3'd4, 1, 1, "R8");
    drive(0, 0, 3'd1, 1, 1, "R8");
    // R1 reset overrides latch mode
    drive(0, 1, 3'd3, 0, 1, "R2");
    drive(1, 1, 3'd3, 0, 1, "R1");
    drive(0, 0, 3'd3, 1, 1, "R4");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule